// File: doc/BRIEF.md
# Program Sequencer with Return Stack

This block drives the 13-bit program counter of a small stack machine with 9-bit opcodes and 8-bit data. On every enabled step it decodes the current opcode. It either advances the counter by one or redirects it for jumps, calls and returns. It also keeps a return stack whose top entry sits in a register R. A branch target joins five high address bits, carried in the opcode, to the 8-bit top-of-stack value T that the previous instruction pushed. Conditional forms test the next-to-top value N instead of a flag register.

The data path supplies T, N and the opcode. The sequencer reports four things back. It asks the data path to pop whenever a branch opcode executes, taken or not. It shows the low byte of R for the instructions that copy R to the data stack or move it there. It raises an interrupt-inhibit flag for the cycle after any branch. It also handles the return side of the transfers between the two stacks. All pins are plain control and status signals with no handshake. When `step_en` is low the block holds its state.

Top module: `prog_seq`

## Requirements
- R1: After reset `pc` is 0, `ret_top` is 0 and `irq_block` is 0.
- R2: A stepped opcode that is neither a branch (`opcode[8:7]==2'b01`) nor a return (0x028) sets `pc` to `pc+1` modulo 8192, so 0x1FFF wraps to 0.
- R3: A branch with `opcode[5]==0` (jump 0x080–0x09F, call 0x0C0–0x0DF) loads `pc` with `{opcode[4:0], tos}`.
- R4: A branch with `opcode[5]==1` (0x0A0–0x0BF, 0x0E0–0x0FF) loads the target only when `nos` is non-zero. Otherwise `pc` becomes `pc+1`.
- R5: A taken call (`opcode[6]==1`) pushes `pc+1` into R, and the previous R moves one slot down. A call that is not taken leaves the return stack unchanged.
- R6: `branch_pop` is high exactly while `step_en` is high and the opcode is a branch, whether the branch is taken or not.
- R7: `irq_block` goes high after a stepped branch and goes low after any other stepped opcode.
- R8: Return (0x028) loads `pc` from R and pops the return stack.
- R9: Opcode 0x040 pushes `{5'b0, tos}` into R. Opcode 0x049 pops the return stack. `r_data` always shows `ret_top[7:0]`, and opcode 0x009 changes nothing on the return side.
- R10: Below R there are `RS_DEPTH` slots used as a ring. Pushing more than `RS_DEPTH` entries beyond R overwrites the oldest ones, and later pops read back whatever the ring holds.
- R11: With `step_en` low, `pc`, `ret_top` and `irq_block` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Execute the current opcode on this edge |
| opcode | input | 9 | Current instruction |
| tos | input | 8 | Data-stack top T |
| nos | input | 8 | Data-stack next-to-top N |
| pc | output | 13 | Program counter |
| ret_top | output | 13 | Return-stack top register R |
| r_data | output | 8 | Low byte of R for the data path |
| branch_pop | output | 1 | Data path must discard T this step |
| irq_block | output | 1 | Interrupts must not be taken this cycle |

## Verification
The bench builds the sequencer with `RS_DEPTH=4`. With that size a run of six pushes followed by six pops passes the ring boundary, so overflow and the stale entries read back after it can be reached in a few dozen cycles. The default depth of 8 is covered only by elaboration. A jump to 0x1FFF followed by a plain step brings the counter wraparound within reach.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  localparam int PC_W   = 13;
  localparam int DATA_W = 8;
  localparam int OP_W   = 9;
  localparam int HI_W   = PC_W - DATA_W;

  localparam logic [OP_W-1:0] OP_RETURN = 9'h028;
  localparam logic [OP_W-1:0] OP_TO_R   = 9'h040;
  localparam logic [OP_W-1:0] OP_FROM_R = 9'h049;

  typedef struct packed {
    logic branch;
    logic cond;
    logic call;
    logic ret;
    logic to_r;
    logic from_r;
  } seq_ctl_t;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import prog_seq_pkg::*;
(
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] nos,
  output seq_ctl_t          ctl,
  output logic              take
);
  always_comb begin
    ctl        = '0;
    ctl.branch = (opcode[8:7] == 2'b01);
    ctl.cond   = ctl.branch & opcode[5];
    ctl.call   = ctl.branch & opcode[6];
    ctl.ret    = (opcode == OP_RETURN);
    ctl.to_r   = (opcode == OP_TO_R);
    ctl.from_r = (opcode == OP_FROM_R);
    take       = ctl.branch & (~ctl.cond | (|nos));
  end
endmodule

// File: rtl/seq_pc.sv
module seq_pc
  import prog_seq_pkg::*;
#(
  parameter int W = PC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  seq_ctl_t     ctl,
  input  logic         take,
  input  logic [W-1:0] target,
  input  logic [W-1:0] ret_addr,
  output logic [W-1:0] pc,
  output logic [W-1:0] link,
  output logic         irq_block
);
  assign link = pc + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= '0;
      irq_block <= 1'b0;
    end else if (step) begin
      irq_block <= ctl.branch;
      if (take)         pc <= target;
      else if (ctl.ret) pc <= ret_addr;
      else              pc <= link;
    end
  end

  a_r3_direct_target: assert property (@(posedge clk) disable iff (!rst_n)
    step && ctl.branch && !ctl.cond |=> pc == $past(target));
  a_r4_cond_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    step && ctl.cond && !take |=> pc == W'($past(pc) + 1'b1));
  a_r7_inhibit_after_branch: assert property (@(posedge clk) disable iff (!rst_n)
    step && ctl.branch |=> irq_block);
  a_r11_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pc) && $stable(irq_block));
endmodule

// File: rtl/seq_rstack.sv
module seq_rstack #(
  parameter int W     = 13,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_val,
  output logic [W-1:0] top
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]     ring [DEPTH];
  logic [PTR_W-1:0] ptr;
  logic [PTR_W-1:0] ptr_dn;

  assign ptr_dn = ptr - 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      top <= '0;
      ptr <= '0;
      for (int i = 0; i < DEPTH; i++) ring[i] <= '0;
    end else if (push) begin
      ring[ptr] <= top;
      ptr       <= ptr + 1'b1;
      top       <= push_val;
    end else if (pop) begin
      top <= ring[ptr_dn];
      ptr <= ptr_dn;
    end
  end

  a_r5_push_lands_on_top: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> top == $past(push_val));
  a_r8_pop_moves_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push |=> ptr == PTR_W'($past(ptr) - 1'b1));
  a_r9_idle_top_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !push && !pop |=> $stable(top));
  a_r10_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int RS_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_en,
  input  logic [OP_W-1:0]   opcode,
  input  logic [DATA_W-1:0] tos,
  input  logic [DATA_W-1:0] nos,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   ret_top,
  output logic [DATA_W-1:0] r_data,
  output logic              branch_pop,
  output logic              irq_block
);
  seq_ctl_t        ctl;
  logic            take;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] link;
  logic [PC_W-1:0] push_val;
  logic            rs_push;
  logic            rs_pop;

  seq_decode u_dec (.opcode(opcode), .nos(nos), .ctl(ctl), .take(take));

  assign target   = {opcode[HI_W-1:0], tos};
  assign rs_push  = step_en & ((take & ctl.call) | ctl.to_r);
  assign rs_pop   = step_en & (ctl.ret | ctl.from_r);
  assign push_val = ctl.to_r ? {{HI_W{1'b0}}, tos} : link;

  seq_pc #(.W(PC_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .step(step_en), .ctl(ctl), .take(take),
    .target(target), .ret_addr(ret_top), .pc(pc), .link(link),
    .irq_block(irq_block)
  );

  seq_rstack #(.W(PC_W), .DEPTH(RS_DEPTH)) u_rs (
    .clk(clk), .rst_n(rst_n), .push(rs_push), .pop(rs_pop),
    .push_val(push_val), .top(ret_top)
  );

  assign r_data     = ret_top[DATA_W-1:0];
  assign branch_pop = step_en & ctl.branch;

  a_r8_return_target: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && opcode == OP_RETURN |=> pc == $past(ret_top));
  a_r5_call_link: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && take && ctl.call |=> ret_top == PC_W'($past(pc) + 1'b1));
  a_r11_stack_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(ret_top));
endmodule

// File: tb/test_prog_seq.sv
module test_prog_seq;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_en = 1'b0;
  logic [8:0] opcode = '0;
  logic [7:0] tos = '0;
  logic [7:0] nos = '0;
  logic [12:0] pc, ret_top;
  logic [7:0] r_data;
  logic       branch_pop, irq_block;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_pc = 0, m_r = 0, m_ptr = 0;
  int m_ring [D];
  bit m_irq = 0;

  prog_seq #(.RS_DEPTH(D)) i_prog_seq (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .opcode(opcode),
    .tos(tos), .nos(nos), .pc(pc), .ret_top(ret_top), .r_data(r_data),
    .branch_pop(branch_pop), .irq_block(irq_block)
  );

  always #4 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic m_push(int v);
    m_ring[m_ptr] = m_r;
    m_ptr = (m_ptr + 1) % D;
    m_r = v;
  endtask

  task automatic m_pop();
    m_ptr = (m_ptr + D - 1) % D;
    m_r = m_ring[m_ptr];
  endtask

  task automatic step(bit en, int op, int t, int n, string tag);
    bit br, take;
    int nxt;
    step_en = en; opcode = op[8:0]; tos = t[7:0]; nos = n[7:0];
    #1;
    br = (op[8:7] == 2'b01);
    chk({tag, "/R6 pop"}, int'(branch_pop), int'(en && br));
    chk({tag, "/R9 rdata"}, int'(r_data), m_r & 255);
    @(posedge clk);
    if (en) begin
      take = br && (!op[5] || n != 0);
      nxt = (m_pc + 1) % 8192;
      if (take) begin
        if (op[6]) m_push(nxt);
        nxt = ((op & 31) << 8) | t;
      end else if (op == 'h028) begin
        nxt = m_r;
        m_pop();
      end else if (op == 'h040) m_push(t);
      else if (op == 'h049) m_pop();
      m_pc = nxt;
      m_irq = br;
    end
    @(negedge clk);
    chk({tag, " pc"}, int'(pc), m_pc);
    chk({tag, " R"}, int'(ret_top), m_r);
    chk({tag, "/R7 irq"}, int'(irq_block), int'(m_irq));
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) m_ring[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 pc", int'(pc), 0);
    chk("R1 R", int'(ret_top), 0);
    chk("R1 irq", int'(irq_block), 0);
    rst_n = 1'b1;
    step(1, 'h000, 0, 0, "R2 nop");
    step(1, 'h123, 9, 9, "R2 push");
    step(1, 'h095, 'h3C, 0, "R3 jump");
    step(1, 'h001, 0, 0, "R7 clear");
    step(1, 'h0A2, 'h10, 0, "R4 jumpc untaken");
    step(1, 'h0A2, 'h10, 5, "R4 jumpc taken");
    step(1, 'h0C7, 'h55, 0, "R5 call");
    step(1, 'h0E3, 'h44, 0, "R5 callc untaken");
    step(1, 'h0E3, 'h44, 1, "R5 callc taken");
    step(1, 'h009, 0, 0, "R9 rfetch");
    step(1, 'h040, 'hA7, 0, "R9 to_r");
    step(1, 'h049, 0, 0, "R9 from_r");
    step(1, 'h028, 0, 0, "R8 return");
    step(1, 'h000, 0, 0, "R8 after");
    step(1, 'h028, 0, 0, "R8 return2");
    step(0, 'h09F, 'hFF, 0, "R11 idle branch");
    step(0, 'h040, 'h12, 0, "R11 idle push");
    step(1, 'h09F, 'hFF, 0, "R2 to top");
    step(1, 'h000, 0, 0, "R2 wrap");
    for (int k = 0; k < 6; k++) step(1, 'h040, 'h30 + k, 0, "R10 fill");
    for (int k = 0; k < 6; k++) step(1, 'h049, 0, 0, "R10 drain");
    step(1, 'h0DF, 'h01, 0, "R10 call over");
    step(1, 'h028, 0, 0, "R10 ret over");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule